// File: doc/BRIEF.md
# UART Register Front-End

This block is the register face of a serial port. A host reaches it over a simple 32-bit, word-addressed read/write bus. It holds the line configuration: data format, baud generator count and baud divider. It turns control writes into transmit and receive enables, and into one-shot flushes of either direction. One data address serves both directions. A write there queues a byte for sending, and a read there takes the oldest received byte.

The shift logic is not part of the block. Its place is taken by two small queues with plain handshake ports on the line side. The serial engine pulls transmit bytes with `tx_pop` and delivers received bytes with `rx_push`. A two-state bus sequencer handles the bus. `BUS_IDLE` is the rest state. The transition *read-issue* (select with write low) moves it to `BUS_RESP`, where `bus_rvalid` is high and `bus_rdata` holds the captured word. From `BUS_RESP`, *read-chain* (another read) stays in `BUS_RESP`, and *read-done* (anything else) returns to `BUS_IDLE`. Writes take effect at the clock edge where they are presented, whatever the state.

Top module: `uart_reg_frontend`

## Requirements
- R1: After reset, control, mode and baud generator read 0, the baud divider reads 15, and status reads 0x002. The enables are low and no transmit byte is available.
- R2: Control is 9 bits wide. Bits 1 and 0 always read back as 0. Bit 4 drives `tx_en` and bit 2 drives `rx_en` from the cycle after the write.
- R3: A control write with bit 1 set empties the transmit queue at that edge. A control write with bit 0 set empties the receive queue at that edge. The other queue is untouched. `tx_soft_rst` or `rx_soft_rst` is high for exactly the one cycle after the write.
- R4: The three configuration registers keep only their low bits and read higher bits as 0. Mode (byte 0x04) keeps 11 bits, the baud generator (0x18) keeps 16 bits and the baud divider (0x34) keeps 8 bits.
- R5: A write to the data port (0x30) queues `bus_wdata[7:0]`. The line side sees the bytes on `tx_data` in write order while `tx_avail` is high, and each `tx_pop` advances the queue by one byte.
- R6: A read of the data port returns the oldest received byte in bits 7:0, with upper bits 0, and removes it from the queue.
- R7: Status (0x2C) bit 4 is 1 while the transmit queue is full. A data write while it is full is discarded.
- R8: Status bit 1 is 1 while the receive queue is empty. A data read while it is empty returns 0 and changes nothing.
- R9: Reads of unused offsets, including 0x08 and 0x38, return 0. Writes to unused offsets and to status change no register.
- R10: Read data appears with `bus_rvalid` high in the cycle after the read request. `bus_rvalid` is low in every cycle that does not follow a read request.
- R11: `rx_full` is high while the receive queue holds FIFO_DEPTH bytes. A `rx_push` while it is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (6) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| tx_soft_rst | output | 1 | One-cycle transmit path reset |
| rx_soft_rst | output | 1 | One-cycle receive path reset |
| cfg_mode | output | 11 | Mode register value |
| cfg_baud_gen | output | 16 | Baud generator count |
| cfg_baud_div | output | 8 | Baud divider |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_pop | input | 1 | Line side takes tx_data |
| rx_data | input | 8 | Received byte from line side |
| rx_push | input | 1 | Line side delivers rx_data |
| rx_full | output | 1 | Receive queue full |

## Verification
The bench fills both queues past their depth. A design that lets an extra write or push through would overwrite the oldest byte or show a wrong order when the queue is drained. It reads the data port on an empty receive queue, where a faulty pop would return stale bytes or skew the pointers for later reads. It flushes one direction while the other holds data, which catches a design that clears both queues or leaves the reset bits stored in control. It also checks reserved and status writes against later readback of every real register, so a loose address decode shows up as a corrupted value.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    // Word indices (byte offset / 4) of the registers
    localparam int IDX_CTRL = 0;
    localparam int IDX_MODE = 1;
    localparam int IDX_BGEN = 6;
    localparam int IDX_STAT = 11;
    localparam int IDX_DATA = 12;
    localparam int IDX_BDIV = 13;

    localparam int CTRL_W = 9;
    localparam int MODE_W = 11;
    localparam int BGEN_W = 16;
    localparam int BDIV_W = 8;
    localparam int STAT_W = 12;
    localparam int BYTE_W = 8;

    // Control bit positions
    localparam int CB_RX_RST = 0;
    localparam int CB_TX_RST = 1;
    localparam int CB_RX_EN  = 2;
    localparam int CB_TX_EN  = 4;

    // Status bit positions
    localparam int SB_RX_EMPTY = 1;
    localparam int SB_TX_FULL  = 4;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
    import uart_rf_pkg::*;
#(
    parameter int BDIV_RESET = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       wdata,
    input  logic              ctrl_we,
    input  logic              mode_we,
    input  logic              bgen_we,
    input  logic              bdiv_we,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [BGEN_W-1:0] bgen_q,
    output logic [BDIV_W-1:0] bdiv_q,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic              tx_rst_pulse,
    output logic              rx_rst_pulse
);
    localparam logic [CTRL_W-1:0] CTRL_KEEP =
        ~((CTRL_W'(1) << CB_TX_RST) | (CTRL_W'(1) << CB_RX_RST));

    assign tx_flush = ctrl_we && wdata[CB_TX_RST];
    assign rx_flush = ctrl_we && wdata[CB_RX_RST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            mode_q       <= '0;
            bgen_q       <= '0;
            bdiv_q       <= BDIV_W'(BDIV_RESET);
            tx_rst_pulse <= 1'b0;
            rx_rst_pulse <= 1'b0;
        end else begin
            if (ctrl_we) ctrl_q <= wdata[CTRL_W-1:0] & CTRL_KEEP;
            if (mode_we) mode_q <= wdata[MODE_W-1:0];
            if (bgen_we) bgen_q <= wdata[BGEN_W-1:0];
            if (bdiv_we) bdiv_q <= wdata[BDIV_W-1:0];
            tx_rst_pulse <= tx_flush;
            rx_rst_pulse <= rx_flush;
        end
    end

endmodule

// File: rtl/uart_rf_bus.sv
module uart_rf_bus
    import uart_rf_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic [MODE_W-1:0] mode_q,
    input  logic [BGEN_W-1:0] bgen_q,
    input  logic [BDIV_W-1:0] bdiv_q,
    input  logic [STAT_W-1:0] status,
    input  logic [BYTE_W-1:0] rx_head,
    input  logic              rx_empty,
    output logic              ctrl_we,
    output logic              mode_we,
    output logic              bgen_we,
    output logic              bdiv_we,
    output logic              data_we,
    output logic              rx_pop,
    output logic [31:0]       rdata,
    output logic              rvalid
);
    localparam int WIW = AW - 2;

    bus_state_e     state_q, state_d;
    logic [WIW-1:0] widx;
    logic           is_rd, is_wr;
    logic [31:0]    rd_mux;

    assign widx  = bus_addr[AW-1:2];
    assign is_rd = bus_sel && !bus_wr;
    assign is_wr = bus_sel && bus_wr;

    // Write strobes
    assign ctrl_we = is_wr && (int'(widx) == IDX_CTRL);
    assign mode_we = is_wr && (int'(widx) == IDX_MODE);
    assign bgen_we = is_wr && (int'(widx) == IDX_BGEN);
    assign bdiv_we = is_wr && (int'(widx) == IDX_BDIV);
    assign data_we = is_wr && (int'(widx) == IDX_DATA);
    assign rx_pop  = is_rd && (int'(widx) == IDX_DATA) && !rx_empty;

    // Read source selection
    always_comb begin
        rd_mux = '0;
        unique case (int'(widx))
            IDX_CTRL: rd_mux = 32'(ctrl_q);
            IDX_MODE: rd_mux = 32'(mode_q);
            IDX_BGEN: rd_mux = 32'(bgen_q);
            IDX_STAT: rd_mux = 32'(status);
            IDX_DATA: rd_mux = rx_empty ? 32'd0 : 32'(rx_head);
            IDX_BDIV: rd_mux = 32'(bdiv_q);
            default:  rd_mux = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: read-issue, read-chain, read-done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = is_rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = is_rd ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (is_rd) begin
            rdata <= rd_mux;
        end
    end

    // Outputs of the sequencer
    always_comb begin
        rvalid = 1'b0;
        unique case (state_q)
            BUS_IDLE: rvalid = 1'b0;
            BUS_RESP: rvalid = 1'b1;
            default:  rvalid = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
    import uart_rf_pkg::*;
#(
    parameter int AW         = 6,
    parameter int FIFO_DEPTH = 4,
    parameter int BDIV_RESET = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              tx_en,
    output logic              rx_en,
    output logic              tx_soft_rst,
    output logic              rx_soft_rst,
    output logic [MODE_W-1:0] cfg_mode,
    output logic [BGEN_W-1:0] cfg_baud_gen,
    output logic [BDIV_W-1:0] cfg_baud_div,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_avail,
    input  logic              tx_pop,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_push,
    output logic              rx_full
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] status;
    logic [BYTE_W-1:0] rx_head;
    logic ctrl_we, mode_we, bgen_we, bdiv_we, data_we, rx_pop;
    logic tx_flush, rx_flush;
    logic tx_full_w, tx_empty_w, rx_empty_w;

    always_comb begin
        status              = '0;
        status[SB_RX_EMPTY] = rx_empty_w;
        status[SB_TX_FULL]  = tx_full_w;
    end

    assign tx_en    = ctrl_q[CB_TX_EN];
    assign rx_en    = ctrl_q[CB_RX_EN];
    assign tx_avail = !tx_empty_w;

    uart_rf_bus #(.AW(AW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .ctrl_q   (ctrl_q),
        .mode_q   (cfg_mode),
        .bgen_q   (cfg_baud_gen),
        .bdiv_q   (cfg_baud_div),
        .status   (status),
        .rx_head  (rx_head),
        .rx_empty (rx_empty_w),
        .ctrl_we  (ctrl_we),
        .mode_we  (mode_we),
        .bgen_we  (bgen_we),
        .bdiv_we  (bdiv_we),
        .data_we  (data_we),
        .rx_pop   (rx_pop),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

    uart_rf_cfg #(.BDIV_RESET(BDIV_RESET)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdata        (bus_wdata[15:0]),
        .ctrl_we      (ctrl_we),
        .mode_we      (mode_we),
        .bgen_we      (bgen_we),
        .bdiv_we      (bdiv_we),
        .ctrl_q       (ctrl_q),
        .mode_q       (cfg_mode),
        .bgen_q       (cfg_baud_gen),
        .bdiv_q       (cfg_baud_div),
        .tx_flush     (tx_flush),
        .rx_flush     (rx_flush),
        .tx_rst_pulse (tx_soft_rst),
        .rx_rst_pulse (rx_soft_rst)
    );

    uart_rf_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (data_we),
        .din   (bus_wdata[BYTE_W-1:0]),
        .pop   (tx_pop),
        .dout  (tx_data),
        .full  (tx_full_w),
        .empty (tx_empty_w)
    );

    uart_rf_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push),
        .din   (rx_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty_w)
    );

endmodule

// File: rtl/uart_reg_frontend_checker.sv
module uart_reg_frontend_checker #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic          bus_rvalid,
    input logic          tx_en,
    input logic          tx_soft_rst,
    input logic          rx_soft_rst,
    input logic          tx_avail,
    input logic          tx_pop,
    input logic          rx_push,
    input logic          tx_full_w,
    input logic          rx_empty_w
);
    logic [AW-3:0] widx;
    logic rd_req, ctrl_wr, data_rd, rsvd_rd;

    assign widx    = bus_addr[AW-1:2];
    assign rd_req  = bus_sel && !bus_wr;
    assign ctrl_wr = bus_sel && bus_wr && (int'(widx) == 0);
    assign data_rd = rd_req && (int'(widx) == 12);
    assign rsvd_rd = rd_req && !(int'(widx) inside {0, 1, 6, 11, 12, 13});

    assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    assert_tx_flush_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soft_rst |-> !tx_avail);

    assert_rx_flush_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soft_rst |-> rx_empty_w);

    assert_ctrl_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (tx_en == $past(bus_wdata[4])));

    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_empty_w && !rx_push) |=> (bus_rdata == 32'd0 && rx_empty_w));

    assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full_w && !tx_pop && !(ctrl_wr && bus_wdata[1])) |=> tx_full_w);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_rd |=> (bus_rdata == 32'd0));

endmodule

bind uart_reg_frontend uart_reg_frontend_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .tx_en       (tx_en),
    .tx_soft_rst (tx_soft_rst),
    .rx_soft_rst (rx_soft_rst),
    .tx_avail    (tx_avail),
    .tx_pop      (tx_pop),
    .rx_push     (rx_push),
    .tx_full_w   (tx_full_w),
    .rx_empty_w  (rx_empty_w)
);

// File: tb/uart_reg_frontend_bench.sv
`timescale 1ns/1ps
module uart_reg_frontend_bench;
    localparam int AW    = 6;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_en, rx_en, tx_soft_rst, rx_soft_rst;
    logic [10:0] cfg_mode;
    logic [15:0] cfg_baud_gen;
    logic [7:0]  cfg_baud_div;
    logic [7:0]  tx_data;
    logic        tx_avail;
    logic        tx_pop = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_push = 1'b0;
    logic        rx_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    uart_reg_frontend #(.AW(AW), .FIFO_DEPTH(DEPTH)) u_uart_reg_frontend (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .tx_en(tx_en), .rx_en(rx_en),
        .tx_soft_rst(tx_soft_rst), .rx_soft_rst(rx_soft_rst),
        .cfg_mode(cfg_mode), .cfg_baud_gen(cfg_baud_gen), .cfg_baud_div(cfg_baud_div),
        .tx_data(tx_data), .tx_avail(tx_avail), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_push(rx_push), .rx_full(rx_full)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic line_push(input logic [7:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic line_take(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(32'(tx_avail), 32'd1, tag);
        check(32'(tx_data), 32'(exp), tag);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    // Monitor: compares each read response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected rvalid actual=0x%0h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=0x%0h expected=0x%0h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check(32'(tx_en), 32'd0, "R1 tx_en");
        check(32'(rx_en), 32'd0, "R1 rx_en");
        check(32'(tx_avail), 32'd0, "R1 tx_avail");
        check(32'(bus_rvalid), 32'd0, "R10 idle rvalid");
        bus_read(6'h00, 32'h0, "R1 ctrl");
        bus_read(6'h04, 32'h0, "R1 mode");
        bus_read(6'h18, 32'h0, "R1 bgen");
        bus_read(6'h34, 32'd15, "R1 bdiv");
        bus_read(6'h2C, 32'h002, "R1 status");

        // R2 control storage and enables, R3 pulses
        bus_write(6'h00, 32'hFFFF_FFFF);
        check(32'(tx_soft_rst), 32'd1, "R3 tx pulse");
        check(32'(rx_soft_rst), 32'd1, "R3 rx pulse");
        check(32'(tx_en), 32'd1, "R2 tx_en");
        check(32'(rx_en), 32'd1, "R2 rx_en");
        @(negedge clk);
        check(32'(tx_soft_rst), 32'd0, "R3 tx pulse width");
        check(32'(rx_soft_rst), 32'd0, "R3 rx pulse width");
        bus_read(6'h00, 32'h1FC, "R2 ctrl readback");

        // R4 field widths
        bus_write(6'h04, 32'hFFFF_FFFF);
        bus_read(6'h04, 32'h7FF, "R4 mode width");
        bus_write(6'h04, 32'h20);
        bus_read(6'h04, 32'h20, "R4 mode value");
        check(32'(cfg_mode), 32'h20, "R4 cfg_mode");
        bus_write(6'h18, 32'hABCD_1234);
        bus_read(6'h18, 32'h1234, "R4 bgen width");
        bus_write(6'h34, 32'h0000_01FF);
        bus_read(6'h34, 32'hFF, "R4 bdiv width");

        // R5 transmit ordering
        bus_write(6'h30, 32'h141);
        bus_write(6'h30, 32'h42);
        line_take(8'h41, "R5 first");
        line_take(8'h42, "R5 second");
        @(negedge clk);
        check(32'(tx_avail), 32'd0, "R5 drained");

        // R7 transmit full
        for (int i = 1; i <= DEPTH + 1; i++) bus_write(6'h30, 32'(i));
        bus_read(6'h2C, 32'h012, "R7 status full");
        for (int i = 1; i <= DEPTH; i++) line_take(8'(i), "R7 order");
        @(negedge clk);
        check(32'(tx_avail), 32'd0, "R7 overflow dropped");

        // R6 / R8 receive path
        line_push(8'h11); line_push(8'h22); line_push(8'h33);
        bus_read(6'h2C, 32'h000, "R8 status not empty");
        bus_read(6'h30, 32'h11, "R6 first");
        bus_read(6'h30, 32'h22, "R6 second");
        bus_read(6'h30, 32'h33, "R6 third");
        bus_read(6'h30, 32'h0, "R8 empty read");
        bus_read(6'h2C, 32'h002, "R8 status empty");

        // R11 receive overflow
        for (int i = 0; i <= DEPTH; i++) line_push(8'hA0 + 8'(i));
        check(32'(rx_full), 32'd1, "R11 rx_full");
        for (int i = 0; i < DEPTH; i++) bus_read(6'h30, 32'hA0 + 32'(i), "R11 order");
        bus_read(6'h30, 32'h0, "R11 extra dropped");

        // R3 independent flush
        bus_write(6'h30, 32'hAA);
        bus_write(6'h30, 32'hBB);
        line_push(8'h55);
        bus_write(6'h00, 32'h02);
        check(32'(tx_soft_rst), 32'd1, "R3 tx only pulse");
        check(32'(rx_soft_rst), 32'd0, "R3 rx untouched pulse");
        check(32'(tx_avail), 32'd0, "R3 tx flushed");
        bus_read(6'h2C, 32'h000, "R3 rx kept");
        bus_read(6'h00, 32'h000, "R3 ctrl self clear");
        bus_write(6'h00, 32'h01);
        bus_read(6'h2C, 32'h002, "R3 rx flushed");

        // R9 reserved and status writes
        bus_write(6'h08, 32'hFFFF_FFFF);
        bus_write(6'h2C, 32'hFFFF_FFFF);
        bus_write(6'h38, 32'hFFFF_FFFF);
        bus_write(6'h3C, 32'hFFFF_FFFF);
        bus_read(6'h08, 32'h0, "R9 reserved 08");
        bus_read(6'h38, 32'h0, "R9 reserved 38");
        bus_read(6'h2C, 32'h002, "R9 status unchanged");
        bus_read(6'h04, 32'h20, "R9 mode unchanged");
        bus_read(6'h18, 32'h1234, "R9 bgen unchanged");
        bus_read(6'h34, 32'hFF, "R9 bdiv unchanged");
        bus_read(6'h00, 32'h0, "R9 ctrl unchanged");

        repeat (3) @(negedge clk);
        check(32'(bus_rvalid), 32'd0, "R10 rvalid idle end");
        check(32'(exp_q.size()), 32'd0, "R10 all responses seen");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule